// File: doc/BRIEF.md
# Frame Sync Source Selector and Alignment Monitor

This block takes three external frame-sync lines and picks one of them, either a fixed line or the one that matches the currently selected reference clock. Each line passes through its own short sampling pipeline. There the per-line phase code decides which tap carries the signal forward. Picking a tap absorbs the board skew: a line may arrive on target, half a reference cycle early, half a cycle late, or a whole cycle late. The block runs on a clock at twice the reference rate, so one clock cycle is half a reference unit interval (UI).

On the compensated signal the block detects falling edges and measures the spacing between consecutive ones against the nominal frame length. It raises a live alarm when the spacing strays from nominal by more than a programmable number of reference cycles, or when an edge fails to arrive in time. The alarm drops again when a well-spaced edge returns. An edge that measures within the limit becomes a one-cycle qualified sync event, but only if the enable controls allow resynchronization. A sticky flag records each onset of the alarm and drives an interrupt through an enable.

Top module: `fsync_sel_monitor`

## Requirements
- R1: With `bypass`=0, line `sync_in[0]` is the monitored input whatever `ref_sel` holds, as long as `ref_sel` is non-zero. With `bypass`=1, `ref_sel` values 1, 2 and 3 select `sync_in[0]`, `sync_in[1]` and `sync_in[2]` respectively.
- R2: While `ref_sel`=0 no line is valid. In the cycle after, `sync_evt` and `alarm_live` are 0, and any stored baseline is discarded.
- R3: The 2-bit phase code of line n sits at `phase_cfg[2n+1:2n]`. Let E be the rising clock edge at which a falling edge is first sampled low. The event it produces shows on `sync_evt` just after edge E+k, with k=4 for code 00 (on target), k=5 for 01 (half UI early), k=3 for 10 (half UI late) and k=2 for 11 (one UI late).
- R4: The period P is the number of clock cycles between two successive compensated falling edges. Misalignment is floor(|P − 2·FRAME_UI| / 2) reference cycles. When it exceeds `limit` (0..7), `alarm_live` goes to 1 together with the edge's would-be event slot.
- R5: Suppose a baseline exists and P reaches 2·FRAME_UI + 2·`limit` + 2 clock cycles with no new edge. Then `alarm_live` is set without waiting for the edge.
- R6: A measured edge whose misalignment is within `limit` clears `alarm_live`.
- R7: The first edge after reset, after a change of the selected line, or after `ref_sel` returns from 0, only sets the baseline. It yields no event and no alarm change.
- R8: The resync enable is `man_en` when `bypass`=0 and (`auto_en` OR `man_en`) when `bypass`=1. With the enable at 0, in-limit edges produce no `sync_evt`.
- R9: `alarm_flag` is set in the same cycle that `alarm_live` rises and stays set until a cycle with `alarm_clr`=1. A rise in that same cycle wins over the clear.
- R10: `irq` is `alarm_flag` AND `irq_en`, registered. It is 0 in the cycle after `irq_en` is 0.
- R11: `sync_evt` is a single-cycle pulse emitted only for in-limit edges, so it is never high together with `alarm_live`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the reference rate |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 3 | External frame-sync lines, bit n is line n |
| ref_sel | input | 2 | Selected reference clock, 0 = none, 1..3 |
| bypass | input | 1 | 1: line follows the reference selection |
| auto_en | input | 1 | Automatic resync enable (used when bypass=1) |
| man_en | input | 1 | Manual resync enable |
| limit | input | 3 | Tolerated misalignment in reference cycles |
| phase_cfg | input | 6 | Per-line 2-bit sampling phase codes |
| irq_en | input | 1 | Interrupt enable |
| alarm_clr | input | 1 | Write-1-to-clear pulse for the sticky flag |
| sync_evt | output | 1 | Qualified resync event, one cycle |
| alarm_live | output | 1 | Current alarm state |
| alarm_flag | output | 1 | Sticky alarm-onset flag |
| irq | output | 1 | Interrupt request |

## Verification
Several relations are checked by the assertions on every cycle. An event never coincides with the alarm, and there is no event or alarm the cycle after the reference is gone. Events are blocked when the enable combination is off. The flag follows each alarm onset and holds until it is cleared, and the interrupt is masked by its enable and implies the flag. Other behaviour needs the bench's scenarios: which line is really selected, the exact event latency for each phase code, the boundary between an in-limit and an out-of-limit period, the timeout on a missing edge and the silent baseline edge after a selection change. The bench shows these by driving lines with different periods and comparing against its cycle-level reference model.

// File: rtl/fsync_mon_pkg.sv
`timescale 1ns/1ps
package fsync_mon_pkg;

  localparam int unsigned NUM_LINES = 3;
  localparam int unsigned IDX_W     = 2;
  localparam int unsigned PH_W      = 2;
  localparam int unsigned TAP_W     = 3;

  typedef enum logic [PH_W-1:0] {
    PH_ON_TARGET  = 2'b00,
    PH_HALF_EARLY = 2'b01,
    PH_HALF_LATE  = 2'b10,
    PH_ONE_LATE   = 2'b11
  } phase_e;

  // Tap in the sampling pipeline per phase code; nominal delay is tap 2.
  function automatic logic [TAP_W-1:0] phase_tap(input logic [PH_W-1:0] code);
    case (phase_e'(code))
      PH_ON_TARGET:  return 3'd2;
      PH_HALF_EARLY: return 3'd3;
      PH_HALF_LATE:  return 3'd1;
      default:       return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/fsync_tap_sampler.sv
`timescale 1ns/1ps
module fsync_tap_sampler
  import fsync_mon_pkg::*;
#(
  parameter int unsigned DEPTH = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            line_in,
  input  logic [PH_W-1:0] phase,
  output logic            fall_q
);

  logic [DEPTH-1:0] shift_q;
  logic [TAP_W-1:0] tap;
  logic             fall_c;

  // Idle-high history so reset cannot fake a falling edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '1;
    end else begin
      shift_q <= {shift_q[DEPTH-2:0], line_in};
    end
  end

  always_comb begin
    tap    = phase_tap(phase);
    fall_c = shift_q[tap + TAP_W'(1)] & ~shift_q[tap];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fall_q <= 1'b0;
    end else begin
      fall_q <= fall_c;
    end
  end

endmodule

// File: rtl/fsync_source_sel.sv
`timescale 1ns/1ps
module fsync_source_sel
  import fsync_mon_pkg::*;
(
  input  logic [IDX_W-1:0] ref_sel,
  input  logic             bypass,
  input  logic             auto_en,
  input  logic             man_en,
  output logic             sel_valid,
  output logic [IDX_W-1:0] sel_idx,
  output logic             sync_allow
);

  always_comb begin
    sel_valid  = (ref_sel != '0);
    sel_idx    = bypass ? (ref_sel - IDX_W'(1)) : '0;
    sync_allow = bypass ? (auto_en | man_en) : man_en;
  end

endmodule

// File: rtl/fsync_align_monitor.sv
`timescale 1ns/1ps
module fsync_align_monitor
  import fsync_mon_pkg::*;
#(
  parameter int unsigned FRAME_UI = 16,
  parameter int unsigned LIMIT_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] fall_vec,
  input  logic                 sel_valid,
  input  logic [IDX_W-1:0]     sel_idx,
  input  logic                 sync_allow,
  input  logic [LIMIT_W-1:0]   limit,
  output logic                 evt_q,
  output logic                 alarm_q,
  output logic                 alarm_rise
);

  localparam int unsigned NOM     = 2 * FRAME_UI;
  localparam int unsigned LIM_MAX = (1 << LIMIT_W) - 1;
  localparam int unsigned CNT_MAX = NOM + 2 * LIM_MAX + 2;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] NOM_C = CNT_W'(NOM);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0] cnt_q, cnt_d, dev, thresh, lim_ext;
  logic             armed_q, armed_d, alarm_d, evt_d;
  logic             sel_vq;
  logic [IDX_W-1:0] sel_q;
  logic             hit, reselect, in_limit;

  always_comb begin
    hit      = (sel_valid && (int'(sel_idx) < NUM_LINES)) ? fall_vec[sel_idx] : 1'b0;
    reselect = !sel_valid || !sel_vq || (sel_idx != sel_q);
    lim_ext  = CNT_W'(limit);
    dev      = (cnt_q >= NOM_C) ? (cnt_q - NOM_C) : (NOM_C - cnt_q);
    thresh   = NOM_C + (lim_ext << 1) + CNT_W'(2);
    in_limit = ((dev >> 1) <= lim_ext);

    cnt_d   = cnt_q;
    armed_d = armed_q;
    alarm_d = alarm_q;
    evt_d   = 1'b0;

    if (reselect) begin
      cnt_d   = '0;
      armed_d = 1'b0;
      alarm_d = 1'b0;
    end else if (hit) begin
      if (armed_q) begin
        alarm_d = !in_limit;
        evt_d   = in_limit && sync_allow;
      end
      armed_d = 1'b1;
      cnt_d   = CNT_W'(1);
    end else if (armed_q) begin
      if (cnt_q >= thresh) begin
        alarm_d = 1'b1;
      end
      if (cnt_q < MAX_C) begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end

    alarm_rise = alarm_d & ~alarm_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      alarm_q <= 1'b0;
      evt_q   <= 1'b0;
      sel_vq  <= 1'b0;
      sel_q   <= '0;
    end else begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
      alarm_q <= alarm_d;
      evt_q   <= evt_d;
      sel_vq  <= sel_valid;
      sel_q   <= sel_idx;
    end
  end

endmodule

// File: rtl/fsync_alarm_report.sv
`timescale 1ns/1ps
module fsync_alarm_report (
  input  logic clk,
  input  logic rst,
  input  logic alarm_rise,
  input  logic clr,
  input  logic irq_en,
  output logic flag_q,
  output logic irq_q
);

  logic flag_d;

  always_comb begin
    if (alarm_rise) begin
      flag_d = 1'b1;
    end else if (clr) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & irq_en;
    end
  end

endmodule

// File: rtl/fsync_sel_monitor.sv
`timescale 1ns/1ps
module fsync_sel_monitor
  import fsync_mon_pkg::*;
#(
  parameter int unsigned FRAME_UI = 16,
  parameter int unsigned LIMIT_W  = 3,
  parameter int unsigned HIST     = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_LINES-1:0]      sync_in,
  input  logic [IDX_W-1:0]          ref_sel,
  input  logic                      bypass,
  input  logic                      auto_en,
  input  logic                      man_en,
  input  logic [LIMIT_W-1:0]        limit,
  input  logic [NUM_LINES*PH_W-1:0] phase_cfg,
  input  logic                      irq_en,
  input  logic                      alarm_clr,
  output logic                      sync_evt,
  output logic                      alarm_live,
  output logic                      alarm_flag,
  output logic                      irq
);

  logic [NUM_LINES-1:0] fall_vec;
  logic                 sel_valid, sync_allow, alarm_rise;
  logic [IDX_W-1:0]     sel_idx;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    fsync_tap_sampler #(.DEPTH(HIST)) u_smp (
      .clk    (clk),
      .rst    (rst),
      .line_in(sync_in[g]),
      .phase  (phase_cfg[g*PH_W +: PH_W]),
      .fall_q (fall_vec[g])
    );
  end

  fsync_source_sel u_sel (
    .ref_sel   (ref_sel),
    .bypass    (bypass),
    .auto_en   (auto_en),
    .man_en    (man_en),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx),
    .sync_allow(sync_allow)
  );

  fsync_align_monitor #(.FRAME_UI(FRAME_UI), .LIMIT_W(LIMIT_W)) u_mon (
    .clk       (clk),
    .rst       (rst),
    .fall_vec  (fall_vec),
    .sel_valid (sel_valid),
    .sel_idx   (sel_idx),
    .sync_allow(sync_allow),
    .limit     (limit),
    .evt_q     (sync_evt),
    .alarm_q   (alarm_live),
    .alarm_rise(alarm_rise)
  );

  fsync_alarm_report u_rpt (
    .clk       (clk),
    .rst       (rst),
    .alarm_rise(alarm_rise),
    .clr       (alarm_clr),
    .irq_en    (irq_en),
    .flag_q    (alarm_flag),
    .irq_q     (irq)
  );

endmodule

// File: rtl/fsync_sel_monitor_chk.sv
`timescale 1ns/1ps
module fsync_sel_monitor_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] ref_sel,
  input logic       bypass,
  input logic       auto_en,
  input logic       man_en,
  input logic       irq_en,
  input logic       alarm_clr,
  input logic       sync_evt,
  input logic       alarm_live,
  input logic       alarm_flag,
  input logic       irq
);

  AST_EVT_NOT_IN_ALARM: assert property (@(posedge clk) disable iff (rst)
    sync_evt |-> !alarm_live); // R11

  AST_NO_REF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (ref_sel == 2'd0) |=> (!sync_evt && !alarm_live)); // R2

  AST_EN_GATES_EVT: assert property (@(posedge clk) disable iff (rst)
    !(bypass ? (auto_en | man_en) : man_en) |=> !sync_evt); // R8

  AST_FLAG_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_live) |-> alarm_flag); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (alarm_flag && !alarm_clr) |=> alarm_flag); // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq); // R10

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> alarm_flag); // R10

endmodule

bind fsync_sel_monitor fsync_sel_monitor_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_sel   (ref_sel),
  .bypass    (bypass),
  .auto_en   (auto_en),
  .man_en    (man_en),
  .irq_en    (irq_en),
  .alarm_clr (alarm_clr),
  .sync_evt  (sync_evt),
  .alarm_live(alarm_live),
  .alarm_flag(alarm_flag),
  .irq       (irq)
);

// File: tb/fsync_sel_monitor_tb.sv
`timescale 1ns/1ps
module fsync_sel_monitor_tb;

  localparam int FRAME_UI = 16;
  localparam int NOM      = 2 * FRAME_UI;
  localparam int CMAX     = NOM + 2 * 7 + 2;

  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] sync_in;
  logic [1:0] ref_sel;
  logic       bypass, auto_en, man_en, irq_en, alarm_clr;
  logic [2:0] limit;
  logic [5:0] phase_cfg;
  logic       sync_evt, alarm_live, alarm_flag, irq;

  always #2 clk = ~clk;

  fsync_sel_monitor #(.FRAME_UI(FRAME_UI)) u_dut (
    .clk(clk), .rst(rst), .sync_in(sync_in), .ref_sel(ref_sel),
    .bypass(bypass), .auto_en(auto_en), .man_en(man_en), .limit(limit),
    .phase_cfg(phase_cfg), .irq_en(irq_en), .alarm_clr(alarm_clr),
    .sync_evt(sync_evt), .alarm_live(alarm_live), .alarm_flag(alarm_flag), .irq(irq)
  );

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";
  bit    finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Line driver: per_cfg = period in clock cycles (0 = held high), low for 4 cycles.
  int per_cfg [3];
  int lcnt    [3];
  always @(negedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (per_cfg[i] == 0) begin
        sync_in[i] = 1'b1;
        lcnt[i] = 0;
      end else begin
        if (lcnt[i] >= per_cfg[i] - 1) lcnt[i] = 0;
        else lcnt[i] = lcnt[i] + 1;
        sync_in[i] = (lcnt[i] >= 4);
      end
    end
  end

  // Behavioural reference model.
  int h [3][5];
  bit fq [3];
  bit m_armed, m_alarm, m_evt, m_flag, m_irq, m_vq;
  int m_cnt, m_sq;

  function automatic int tap_of(input logic [1:0] c);
    case (c)
      2'b00: return 2;
      2'b01: return 3;
      2'b10: return 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        fq[i] = 0;
        for (int j = 0; j < 5; j++) h[i][j] = 1;
      end
      m_armed = 0; m_alarm = 0; m_evt = 0; m_flag = 0; m_irq = 0; m_vq = 0;
      m_cnt = 0; m_sq = 0;
    end else begin
      bit valid, allow, d, nxt, rise;
      int idx, dev;
      valid = (ref_sel != 0);
      idx   = bypass ? int'(ref_sel) - 1 : 0;
      allow = bypass ? (auto_en || man_en) : man_en;
      d     = (valid && idx >= 0) ? fq[idx] : 0;
      nxt   = m_alarm;
      m_evt = 0;
      if (!valid || !m_vq || idx != m_sq) begin
        m_armed = 0; m_cnt = 0; nxt = 0;
      end else if (d) begin
        if (m_armed) begin
          dev = (m_cnt >= NOM) ? m_cnt - NOM : NOM - m_cnt;
          if (dev / 2 > int'(limit)) nxt = 1;
          else begin nxt = 0; m_evt = allow; end
        end
        m_armed = 1; m_cnt = 1;
      end else if (m_armed) begin
        if (m_cnt >= NOM + 2 * int'(limit) + 2) nxt = 1;
        if (m_cnt < CMAX) m_cnt = m_cnt + 1;
      end
      rise    = nxt && !m_alarm;
      m_flag  = rise ? 1 : (alarm_clr ? 0 : m_flag);
      m_irq   = m_flag && irq_en;
      m_alarm = nxt;
      m_vq    = valid;
      m_sq    = idx;
      for (int i = 0; i < 3; i++) begin
        int t;
        t = tap_of(phase_cfg[2*i +: 2]);
        fq[i] = (h[i][t+1] == 1) && (h[i][t] == 0);
        for (int j = 4; j > 0; j--) h[i][j] = h[i][j-1];
        h[i][0] = sync_in[i];
      end
    end
  end

  // Per-cycle comparison, plus event counting for the directed checks.
  int ev_cnt = 0;
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      check({sync_evt, alarm_live, alarm_flag, irq} == {m_evt, m_alarm, m_flag, m_irq},
            cur_req, "outputs{evt,alarm,flag,irq}",
            int'({sync_evt, alarm_live, alarm_flag, irq}),
            int'({m_evt, m_alarm, m_flag, m_irq}));
      if (sync_evt) ev_cnt++;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      check(0, "WDOG", "watchdog expired", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; sync_in = '1; ref_sel = 2'd2; bypass = 0; auto_en = 0; man_en = 1;
    limit = 3'd1; phase_cfg = '0; irq_en = 1; alarm_clr = 0;
    per_cfg[0] = 0; per_cfg[1] = 0; per_cfg[2] = 0;
    lcnt[0] = 0; lcnt[1] = 0; lcnt[2] = 0;
    run(4);
    check({sync_evt, alarm_live, alarm_flag, irq} == 4'b0, "RESET", "reset outputs",
          int'({sync_evt, alarm_live, alarm_flag, irq}), 0);
    @(negedge clk); rst = 0; cmp_on = 1;

    // R1 bypass off: line 0 used although ref_sel=2; line 1 badly spaced. R7 baseline.
    cur_req = "R1"; per_cfg[0] = 32; per_cfg[1] = 20; ev_cnt = 0;
    run(300);
    check(ev_cnt >= 6, "R1", "events from line0 with bypass off", ev_cnt, 6);
    check(alarm_live == 0, "R1", "no alarm on good line0", alarm_live, 0);

    // R1 bypass on, ref 2 -> line 1 (R7: first edge after change is baseline only)
    cur_req = "R7"; bypass = 1; per_cfg[0] = 20; per_cfg[1] = 32; ev_cnt = 0;
    run(300);
    check(ev_cnt >= 6, "R1", "events from line1 with ref 2", ev_cnt, 6);
    check(alarm_live == 0, "R1", "no alarm on line1", alarm_live, 0);

    cur_req = "R1"; ref_sel = 2'd3; per_cfg[1] = 20; per_cfg[2] = 32; ev_cnt = 0;
    run(300);
    check(ev_cnt >= 6, "R1", "events from line2 with ref 3", ev_cnt, 6);

    // R4 boundary: period 35 -> misalignment 1 = limit, ok; 36 -> 2 > limit
    cur_req = "R4"; per_cfg[2] = 35; ev_cnt = 0;
    run(250);
    check(alarm_live == 0, "R4", "period 35 within limit 1", alarm_live, 0);
    check(ev_cnt >= 4, "R4", "events at period 35", ev_cnt, 4);
    per_cfg[2] = 36;
    run(120);
    ev_cnt = 0;
    run(120);
    check(alarm_live == 1, "R4", "period 36 beyond limit 1", alarm_live, 1);
    check(ev_cnt == 0, "R11", "no events while in alarm", ev_cnt, 0);
    check(alarm_flag == 1, "R9", "flag set on alarm", alarm_flag, 1);
    check(irq == 1, "R10", "irq with enable", irq, 1);

    cur_req = "R10"; irq_en = 0; run(2);
    check(irq == 0, "R10", "irq masked", irq, 0);

    cur_req = "R9"; alarm_clr = 1; run(1); alarm_clr = 0; run(3);
    check(alarm_flag == 0, "R9", "flag cleared by write-1", alarm_flag, 0);

    cur_req = "R6"; per_cfg[2] = 32; run(150);
    check(alarm_live == 0, "R6", "alarm self-clears", alarm_live, 0);
    check(alarm_flag == 0, "R9", "flag stays clear without new rise", alarm_flag, 0);

    cur_req = "R10"; per_cfg[2] = 36; run(200);
    check(alarm_flag == 1 && irq == 0, "R10", "flag set, irq masked",
          int'({alarm_flag, irq}), 2);
    irq_en = 1; run(2);
    check(irq == 1, "R10", "irq after enable", irq, 1);
    alarm_clr = 1; run(1); alarm_clr = 0;
    per_cfg[2] = 32; run(150);

    // R5 missing edge
    cur_req = "R5"; per_cfg[2] = 0; run(100);
    check(alarm_live == 1, "R5", "timeout on missing edge", alarm_live, 1);
    alarm_clr = 1; run(1); alarm_clr = 0;
    per_cfg[2] = 32; run(150);
    check(alarm_live == 0, "R6", "recovered after edges return", alarm_live, 0);

    // R2 no reference
    cur_req = "R2"; ref_sel = 2'd0; ev_cnt = 0; run(150);
    check(ev_cnt == 0 && alarm_live == 0, "R2", "quiet with no reference",
          ev_cnt, 0);

    // R3 each phase code on line 0
    cur_req = "R3"; ref_sel = 2'd1; per_cfg[0] = 32;
    for (int c = 0; c < 4; c++) begin
      phase_cfg[1:0] = 2'(c); ev_cnt = 0;
      run(200);
      check(ev_cnt >= 4, "R3", "events with phase code", ev_cnt, 4);
    end
    phase_cfg = '0;

    // R8 enable combinations, ref 1 so the line stays the same for either bypass
    cur_req = "R8";
    for (int k = 0; k < 8; k++) begin
      bit exp_on;
      bypass = k[2]; auto_en = k[1]; man_en = k[0];
      exp_on = bypass ? (auto_en || man_en) : man_en;
      run(40); ev_cnt = 0; run(100);
      check((ev_cnt > 0) == exp_on, "R8", "enable combination", ev_cnt, int'(exp_on));
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule